// File: doc/BRIEF.md
# I/O Register Space Decoder

This block is the peripheral register space of a small 8-bit processor core. The core reaches one shared bank of 64 I/O registers in two ways. A port access carries a 6-bit I/O address. A data-space load or store carries an 8-bit address, and there the same registers sit 0x20 higher. Above the I/O window, data-space accesses reach an extended register region. When a compatibility-mode input is high, that region is swapped for plain RAM bytes.

Single-bit set, clear and test requests are accepted only for the lowest 32 I/O registers. The first few I/O registers hold status flags. Hardware events set these flags, and software clears them by writing a one. A bit set or clear rewrites the whole register, so it also clears any other flag that currently reads as one. Data addresses below 0x20 are not decoded here. They are only flagged as general-register accesses for the core to handle.

All updates happen on the rising clock edge. Read data is combinational from the address presented in the same cycle.

Top module: `iosp_regspace`

## Requirements
- R1: Operation codes are PORT_RD=0 and PORT_WR=1. A port access to address N in 0x00..0x3F reads or writes I/O register N. A port access with address 0x40 or above raises `acc_reject` and changes no state.
- R2: Operation codes are DATA_RD=2 and DATA_WR=3. A data access to address 0x20..0x5F reaches the same I/O register as port address (address − 0x20).
- R3: Operation codes are BIT_SET=4, BIT_CLR=5 and BIT_TEST=6, and the bit number is `acc_bit`. These operations are accepted only for I/O addresses 0x00..0x1F. BIT_TEST returns the selected bit on `bit_val` and the whole register on `rd_data`. A bit operation at 0x20 or above raises `acc_reject`, returns 0 and changes no state. `bit_val` is 0 for every other operation.
- R4: While `compat_mode` is 0, data addresses 0x60..0xFF reach the extended registers, with index (address − 0x60). A port access can never reach them.
- R5: While `compat_mode` is 1, data addresses 0x60..0xFF reach a 160-byte RAM instead. The extended registers keep their contents during that time.
- R6: I/O registers 0x00..FLAG_REGS−1 (0x00 and 0x01 by default) are status-flag registers. Writing a 1 to a flag bit clears it, and writing a 0 leaves it unchanged.
- R7: BIT_SET and BIT_CLR write back the current register value with only the selected bit changed. On a flag register, every other flag that reads as 1 is therefore cleared as well.
- R8: Accesses to the following are ignored for writes and read as 0: I/O registers at or above IO_IMPL (48 by default), and extended offsets at or above EXT_IMPL (16 by default, which covers data addresses 0x70..0xFF). Flag bits at or above FLAG_BITS (6 by default) always read 0.
- R9: Bit k of flag register r is set at the next edge when `hw_flag_set[r*8+k]` is high. This set wins over a software clear of the same bit in the same cycle.
- R10: A data access to 0x00..0x1F raises `gpr_hit`, returns 0, is not rejected and changes no state.
- R11: Synchronous reset clears all registers and the RAM to zero. Read data follows the presented address in the same cycle.
- R12: Operation code 7 is undefined. It raises `acc_reject` and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access request present this cycle |
| acc_op | input | 3 | Operation code (see R1, R2, R3, R12) |
| acc_addr | input | 8 | Address: the I/O address for port and bit operations, the data address otherwise |
| acc_bit | input | 3 | Bit number for bit operations |
| acc_wdata | input | 8 | Write data for port and data writes |
| compat_mode | input | 1 | High: the extended region is replaced by RAM |
| hw_flag_set | input | FLAG_REGS*8 | Per-bit hardware set events for the flag registers |
| rd_data | output | 8 | Read data of a read or bit-test access, otherwise 0 |
| bit_val | output | 1 | Selected bit of a bit-test access |
| acc_reject | output | 1 | Request refused (range or operation code) |
| gpr_hit | output | 1 | Data address falls in the general-register window |

## Verification
The hardest situation to reach is a flag register under several writers in the same cycle. Examples are a hardware set landing on the very edge where software clears the same bit, or a bit operation whose read-modify-write wipes neighbouring flags. The stimulus first raises chosen flags with event pulses on idle cycles. It then issues the clear or the bit operation with an event pulse aligned to that same cycle. A behavioural model predicts the surviving flags, and the register is read back through a port access.

// File: rtl/iosp_pkg.sv
package iosp_pkg;

    localparam int unsigned IO_SPAN      = 64;
    localparam logic [7:0]  DATA_IO_BASE = 8'h20;
    localparam logic [7:0]  EXT_BASE     = 8'h60;
    localparam logic [7:0]  BIT_WINDOW   = 8'h20;
    localparam logic [7:0]  PORT_LIMIT   = 8'h40;

    typedef enum logic [2:0] {
        OP_PORT_RD  = 3'd0,
        OP_PORT_WR  = 3'd1,
        OP_DATA_RD  = 3'd2,
        OP_DATA_WR  = 3'd3,
        OP_BIT_SET  = 3'd4,
        OP_BIT_CLR  = 3'd5,
        OP_BIT_TEST = 3'd6,
        OP_UNDEF    = 3'd7
    } acc_op_e;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_GPR  = 3'd1,
        TGT_IO   = 3'd2,
        TGT_EXT  = 3'd3,
        TGT_RAM  = 3'd4
    } tgt_e;

    typedef struct packed {
        tgt_e       tgt;
        logic [7:0] idx;
        logic       rd;
        logic       wr;
        logic       bitop;
        logic       reject;
    } dec_t;

endpackage

// File: rtl/iosp_decode.sv
module iosp_decode
    import iosp_pkg::*;
(
    input  logic       acc_valid,
    input  logic [2:0] acc_op,
    input  logic [7:0] acc_addr,
    input  logic       compat_mode,
    output dec_t       dec
);

    acc_op_e op;

    always_comb begin
        op         = acc_op_e'(acc_op);
        dec        = '0;
        dec.tgt    = TGT_NONE;
        if (acc_valid) begin
            unique case (op)
                OP_PORT_RD, OP_PORT_WR: begin
                    if (acc_addr >= PORT_LIMIT) begin
                        dec.reject = 1'b1;
                    end else begin
                        dec.tgt = TGT_IO;
                        dec.idx = acc_addr;
                        dec.rd  = (op == OP_PORT_RD);
                        dec.wr  = (op == OP_PORT_WR);
                    end
                end
                OP_DATA_RD, OP_DATA_WR: begin
                    if (acc_addr < DATA_IO_BASE) begin
                        dec.tgt = TGT_GPR;
                    end else if (acc_addr < EXT_BASE) begin
                        dec.tgt = TGT_IO;
                        dec.idx = acc_addr - DATA_IO_BASE;
                        dec.rd  = (op == OP_DATA_RD);
                        dec.wr  = (op == OP_DATA_WR);
                    end else begin
                        dec.tgt = compat_mode ? TGT_RAM : TGT_EXT;
                        dec.idx = acc_addr - EXT_BASE;
                        dec.rd  = (op == OP_DATA_RD);
                        dec.wr  = (op == OP_DATA_WR);
                    end
                end
                OP_BIT_SET, OP_BIT_CLR, OP_BIT_TEST: begin
                    if (acc_addr >= BIT_WINDOW) begin
                        dec.reject = 1'b1;
                    end else begin
                        dec.tgt   = TGT_IO;
                        dec.idx   = acc_addr;
                        dec.bitop = 1'b1;
                        dec.rd    = (op == OP_BIT_TEST);
                        dec.wr    = (op != OP_BIT_TEST);
                    end
                end
                default: begin
                    dec.reject = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/iosp_io_bank.sv
module iosp_io_bank #(
    parameter int unsigned IO_IMPL   = 48,
    parameter int unsigned FLAG_REGS = 2,
    parameter int unsigned FLAG_BITS = 6,
    parameter int unsigned IDX_W     = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [IDX_W-1:0]       widx,
    input  logic [7:0]             wdata,
    input  logic [IDX_W-1:0]       ridx,
    output logic [7:0]             rdata,
    input  logic [FLAG_REGS*8-1:0] hw_set,
    output logic [FLAG_REGS*8-1:0] flag_q
);

    localparam int unsigned      AW    = (IO_IMPL > 1) ? $clog2(IO_IMPL) : 1;
    localparam logic [IDX_W:0]   LIMIT = (IDX_W+1)'(IO_IMPL);
    localparam logic [7:0]       FMASK = (FLAG_BITS >= 8) ? 8'hFF
                                       : ((8'd1 << FLAG_BITS) - 8'd1);

    logic [7:0] regs [IO_IMPL];

    for (genvar g = 0; g < IO_IMPL; g++) begin : g_reg
        logic hit;
        assign hit = we && (widx == IDX_W'(g));
        if (g < FLAG_REGS) begin : g_flag
            logic [7:0] clr;
            assign clr = hit ? wdata : 8'h00;
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[g] <= 8'h00;
                end else begin
                    regs[g] <= ((regs[g] & ~clr) | hw_set[g*8 +: 8]) & FMASK;
                end
            end
            assign flag_q[g*8 +: 8] = regs[g];
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[g] <= 8'h00;
                end else if (hit) begin
                    regs[g] <= wdata;
                end
            end
        end
    end

    always_comb begin
        if ({1'b0, ridx} < LIMIT) begin
            rdata = regs[ridx[AW-1:0]];
        end else begin
            rdata = 8'h00;
        end
    end

endmodule

// File: rtl/iosp_byte_bank.sv
module iosp_byte_bank #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);

    localparam int unsigned    AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DEPTH);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'h00;
            end
        end else if (we && ({1'b0, widx} < LIMIT)) begin
            mem[widx[AW-1:0]] <= wdata;
        end
    end

    always_comb begin
        if ({1'b0, ridx} < LIMIT) begin
            rdata = mem[ridx[AW-1:0]];
        end else begin
            rdata = 8'h00;
        end
    end

endmodule

// File: rtl/iosp_regspace.sv
module iosp_regspace
    import iosp_pkg::*;
#(
    parameter int unsigned IO_IMPL   = 48,
    parameter int unsigned FLAG_REGS = 2,
    parameter int unsigned FLAG_BITS = 6,
    parameter int unsigned EXT_IMPL  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   acc_valid,
    input  logic [2:0]             acc_op,
    input  logic [7:0]             acc_addr,
    input  logic [2:0]             acc_bit,
    input  logic [7:0]             acc_wdata,
    input  logic                   compat_mode,
    input  logic [FLAG_REGS*8-1:0] hw_flag_set,
    output logic [7:0]             rd_data,
    output logic                   bit_val,
    output logic                   acc_reject,
    output logic                   gpr_hit
);

    localparam int unsigned RAM_DEPTH = 256 - int'(EXT_BASE);
    localparam int unsigned IO_IDX_W  = $clog2(IO_SPAN);

    dec_t                   dec;
    logic [7:0]             io_rd;
    logic [7:0]             ext_rd;
    logic [7:0]             ram_rd;
    logic [7:0]             sel_rd;
    logic [7:0]             bit_mask;
    logic [7:0]             wr_value;
    logic                   io_we;
    logic                   ext_we;
    logic                   ram_we;
    logic [FLAG_REGS*8-1:0] flag_vec;

    iosp_decode u_dec (
        .acc_valid   (acc_valid),
        .acc_op      (acc_op),
        .acc_addr    (acc_addr),
        .compat_mode (compat_mode),
        .dec         (dec)
    );

    always_comb begin
        unique case (dec.tgt)
            TGT_IO:  sel_rd = io_rd;
            TGT_EXT: sel_rd = ext_rd;
            TGT_RAM: sel_rd = ram_rd;
            default: sel_rd = 8'h00;
        endcase
    end

    assign bit_mask = 8'h01 << acc_bit;

    always_comb begin
        if (!dec.bitop) begin
            wr_value = acc_wdata;
        end else if (acc_op_e'(acc_op) == OP_BIT_SET) begin
            wr_value = sel_rd | bit_mask;
        end else begin
            wr_value = sel_rd & ~bit_mask;
        end
    end

    assign io_we  = dec.wr && (dec.tgt == TGT_IO);
    assign ext_we = dec.wr && (dec.tgt == TGT_EXT);
    assign ram_we = dec.wr && (dec.tgt == TGT_RAM);

    iosp_io_bank #(
        .IO_IMPL   (IO_IMPL),
        .FLAG_REGS (FLAG_REGS),
        .FLAG_BITS (FLAG_BITS),
        .IDX_W     (IO_IDX_W)
    ) u_io (
        .clk    (clk),
        .rst    (rst),
        .we     (io_we),
        .widx   (dec.idx[IO_IDX_W-1:0]),
        .wdata  (wr_value),
        .ridx   (dec.idx[IO_IDX_W-1:0]),
        .rdata  (io_rd),
        .hw_set (hw_flag_set),
        .flag_q (flag_vec)
    );

    iosp_byte_bank #(
        .DEPTH (EXT_IMPL),
        .IDX_W (8)
    ) u_ext (
        .clk   (clk),
        .rst   (rst),
        .we    (ext_we),
        .widx  (dec.idx),
        .wdata (wr_value),
        .ridx  (dec.idx),
        .rdata (ext_rd)
    );

    iosp_byte_bank #(
        .DEPTH (RAM_DEPTH),
        .IDX_W (8)
    ) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .widx  (dec.idx),
        .wdata (wr_value),
        .ridx  (dec.idx),
        .rdata (ram_rd)
    );

    assign rd_data    = dec.rd ? sel_rd : 8'h00;
    assign bit_val    = dec.rd && dec.bitop && sel_rd[acc_bit];
    assign acc_reject = dec.reject;
    assign gpr_hit    = (dec.tgt == TGT_GPR);

endmodule

// File: rtl/iosp_checker.sv
module iosp_checker #(
    parameter int unsigned FLAG_REGS = 2,
    parameter int unsigned FLAG_BITS = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   acc_valid,
    input  logic [2:0]             acc_op,
    input  logic [7:0]             acc_addr,
    input  logic [7:0]             rd_data,
    input  logic                   bit_val,
    input  logic                   acc_reject,
    input  logic                   gpr_hit,
    input  logic [FLAG_REGS*8-1:0] hw_flag_set,
    input  logic [FLAG_REGS*8-1:0] flag_q
);

    localparam logic [7:0] FMASK = (FLAG_BITS >= 8) ? 8'hFF
                                 : ((8'd1 << FLAG_BITS) - 8'd1);

    logic [FLAG_REGS*8-1:0] mask_vec;
    logic [FLAG_REGS*8-1:0] hw_m;

    for (genvar g = 0; g < FLAG_REGS; g++) begin : g_mask
        assign mask_vec[g*8 +: 8] = FMASK;
    end

    assign hw_m = hw_flag_set & mask_vec;

    AST_PORT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (acc_op <= 3'd1) && (acc_addr >= 8'h40)) |-> acc_reject); // R1

    AST_BITOP_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (acc_op >= 3'd4) && (acc_op <= 3'd6) && (acc_addr >= 8'h20))
        |-> (acc_reject && !bit_val)); // R3

    AST_TEST_ONLY_BIT: assert property (@(posedge clk) disable iff (rst)
        bit_val |-> (acc_valid && (acc_op == 3'd6))); // R3

    AST_RSVD_FLAG_BITS: assert property (@(posedge clk) disable iff (rst)
        (flag_q & ~mask_vec) == '0); // R8

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (hw_m != '0) |=> ((flag_q & $past(hw_m)) == $past(hw_m))); // R9

    AST_GPR_QUIET: assert property (@(posedge clk) disable iff (rst)
        gpr_hit |-> ((rd_data == 8'h00) && !acc_reject)); // R10

    AST_UNDEF_OP: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (acc_op == 3'd7)) |-> acc_reject); // R12

endmodule

bind iosp_regspace iosp_checker #(
    .FLAG_REGS (FLAG_REGS),
    .FLAG_BITS (FLAG_BITS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_op      (acc_op),
    .acc_addr    (acc_addr),
    .rd_data     (rd_data),
    .bit_val     (bit_val),
    .acc_reject  (acc_reject),
    .gpr_hit     (gpr_hit),
    .hw_flag_set (hw_flag_set),
    .flag_q      (flag_vec)
);

// File: tb/iosp_regspace_bench.sv
module iosp_regspace_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_op = 3'd0;
    logic [7:0]  acc_addr = 8'h00;
    logic [2:0]  acc_bit = 3'd0;
    logic [7:0]  acc_wdata = 8'h00;
    logic        compat_mode = 1'b0;
    logic [15:0] hw_flag_set = 16'h0000;
    logic [7:0]  rd_data;
    logic        bit_val;
    logic        acc_reject;
    logic        gpr_hit;

    int checks = 0;
    int failures = 0;

    logic [7:0] io_m  [64];
    logic [7:0] ext_m [16];
    logic [7:0] ram_m [160];

    always #10 clk = ~clk;

    iosp_regspace u_iosp_regspace (
        .clk         (clk),
        .rst         (rst),
        .acc_valid   (acc_valid),
        .acc_op      (acc_op),
        .acc_addr    (acc_addr),
        .acc_bit     (acc_bit),
        .acc_wdata   (acc_wdata),
        .compat_mode (compat_mode),
        .hw_flag_set (hw_flag_set),
        .rd_data     (rd_data),
        .bit_val     (bit_val),
        .acc_reject  (acc_reject),
        .gpr_hit     (gpr_hit)
    );

    task automatic model_clear();
        foreach (io_m[i])  io_m[i]  = 8'h00;
        foreach (ext_m[i]) ext_m[i] = 8'h00;
        foreach (ram_m[i]) ram_m[i] = 8'h00;
    endtask

    function automatic logic [7:0] mread(int kind, int idx);
        case (kind)
            2: return (idx < 48) ? io_m[idx] : 8'h00;
            3: return (idx < 16) ? ext_m[idx] : 8'h00;
            4: return ram_m[idx];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s got=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic acc(bit v, logic [2:0] op, logic [7:0] a, logic [2:0] b,
                       logic [7:0] wd, bit cm, logic [15:0] hw, string tag);
        int kind = 0;
        int idx = 0;
        bit rej = 0, rd = 0, wr = 0, bop = 0;
        logic [7:0] rv, wv, erd;
        bit ebit;
        @(negedge clk);
        acc_valid = v; acc_op = op; acc_addr = a; acc_bit = b;
        acc_wdata = wd; compat_mode = cm; hw_flag_set = hw;
        if (v) begin
            if (op <= 3'd1) begin
                if (a >= 8'h40) rej = 1;
                else begin kind = 2; idx = int'(a); rd = (op == 3'd0); wr = (op == 3'd1); end
            end else if (op <= 3'd3) begin
                if (a < 8'h20) kind = 1;
                else if (a < 8'h60) begin kind = 2; idx = int'(a) - 32; end
                else begin kind = cm ? 4 : 3; idx = int'(a) - 96; end
                if (kind != 1) begin rd = (op == 3'd2); wr = (op == 3'd3); end
            end else if (op <= 3'd6) begin
                if (a >= 8'h20) rej = 1;
                else begin kind = 2; idx = int'(a); bop = 1; rd = (op == 3'd6); wr = (op != 3'd6); end
            end else begin
                rej = 1;
            end
        end
        rv   = mread(kind, idx);
        wv   = !bop ? wd : ((op == 3'd4) ? (rv | (8'h01 << b)) : (rv & ~(8'h01 << b)));
        erd  = rd ? rv : 8'h00;
        ebit = (rd && bop) ? rv[b] : 1'b0;
        #2;
        chk(tag, "rd_data", int'(rd_data), int'(erd));
        chk(tag, "bit_val", int'(bit_val), int'(ebit));
        chk(tag, "acc_reject", int'(acc_reject), int'(rej));
        chk(tag, "gpr_hit", int'(gpr_hit), (kind == 1) ? 1 : 0);
        @(posedge clk);
        #1;
        if (wr) begin
            if (kind == 2 && idx < 48) begin
                if (idx < 2) io_m[idx] = io_m[idx] & ~wv;
                else         io_m[idx] = wv;
            end else if (kind == 3 && idx < 16) begin
                ext_m[idx] = wv;
            end else if (kind == 4) begin
                ram_m[idx] = wv;
            end
        end
        for (int r = 0; r < 2; r++) begin
            io_m[r] = (io_m[r] | hw[r*8 +: 8]) & 8'h3F;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_valid = 1'b0; hw_flag_set = 16'h0000;
        @(posedge clk);
        #1;
        model_clear();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired got=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: reset state read at once
        acc(1, 3'd0, 8'h05, 0, 0, 0, 0, "R11");
        acc(1, 3'd2, 8'h25, 0, 0, 0, 0, "R11");
        acc(1, 3'd2, 8'h60, 0, 0, 0, 0, "R11");

        // R1 / R2 aliases
        acc(1, 3'd1, 8'h05, 0, 8'hA5, 0, 0, "R1");
        acc(1, 3'd0, 8'h05, 0, 0, 0, 0, "R1");
        acc(1, 3'd2, 8'h25, 0, 0, 0, 0, "R2");
        acc(1, 3'd3, 8'h30, 0, 8'h3C, 0, 0, "R2");
        acc(1, 3'd0, 8'h10, 0, 0, 0, 0, "R2");
        acc(1, 3'd1, 8'h2F, 0, 8'h77, 0, 0, "R1");
        acc(1, 3'd2, 8'h4F, 0, 0, 0, 0, "R2");
        acc(1, 3'd1, 8'h3F, 0, 8'hEE, 0, 0, "R8");
        acc(1, 3'd0, 8'h3F, 0, 0, 0, 0, "R8");
        acc(1, 3'd0, 8'h45, 0, 0, 0, 0, "R1");

        // R4 extended region, port cannot reach it
        acc(1, 3'd3, 8'h60, 0, 8'h11, 0, 0, "R4");
        acc(1, 3'd3, 8'h6F, 0, 8'h22, 0, 0, "R4");
        acc(1, 3'd1, 8'h60, 0, 8'hFF, 0, 0, "R4");
        acc(1, 3'd2, 8'h60, 0, 0, 0, 0, "R4");
        acc(1, 3'd2, 8'h6F, 0, 0, 0, 0, "R4");
        acc(1, 3'd3, 8'h70, 0, 8'h33, 0, 0, "R8");
        acc(1, 3'd2, 8'h70, 0, 0, 0, 0, "R8");

        // R5 compatibility RAM
        acc(1, 3'd2, 8'h60, 0, 0, 1, 0, "R5");
        acc(1, 3'd3, 8'h60, 0, 8'h99, 1, 0, "R5");
        acc(1, 3'd3, 8'hFF, 0, 8'h5A, 1, 0, "R5");
        acc(1, 3'd3, 8'h70, 0, 8'h44, 1, 0, "R5");
        acc(1, 3'd2, 8'h60, 0, 0, 1, 0, "R5");
        acc(1, 3'd2, 8'hFF, 0, 0, 1, 0, "R5");
        acc(1, 3'd2, 8'h70, 0, 0, 1, 0, "R5");
        acc(1, 3'd2, 8'h60, 0, 0, 0, 0, "R5");
        acc(1, 3'd2, 8'h70, 0, 0, 0, 0, "R5");

        // R3 bit operations inside and outside the window
        acc(1, 3'd4, 8'h05, 3'd1, 0, 0, 0, "R3");
        acc(1, 3'd5, 8'h05, 3'd7, 0, 0, 0, "R3");
        acc(1, 3'd0, 8'h05, 0, 0, 0, 0, "R3");
        acc(1, 3'd6, 8'h05, 3'd2, 0, 0, 0, "R3");
        acc(1, 3'd6, 8'h05, 3'd3, 0, 0, 0, "R3");
        acc(1, 3'd4, 8'h20, 3'd0, 0, 0, 0, "R3");
        acc(1, 3'd0, 8'h20, 0, 0, 0, 0, "R3");
        acc(1, 3'd6, 8'h25, 3'd0, 0, 0, 0, "R3");

        // R6 flag set by events, cleared by writing one
        acc(0, 3'd0, 8'h00, 0, 0, 0, 16'h00A5, "R6");
        acc(1, 3'd0, 8'h00, 0, 0, 0, 0, "R8");
        acc(1, 3'd1, 8'h00, 0, 8'h04, 0, 0, "R6");
        acc(1, 3'd0, 8'h00, 0, 0, 0, 0, "R6");
        acc(1, 3'd1, 8'h00, 0, 8'h00, 0, 0, "R6");
        acc(1, 3'd0, 8'h00, 0, 0, 0, 0, "R6");

        // R7 read-modify-write side effect
        acc(1, 3'd4, 8'h00, 3'd3, 0, 0, 0, "R7");
        acc(1, 3'd0, 8'h00, 0, 0, 0, 0, "R7");
        acc(0, 3'd0, 8'h00, 0, 0, 0, 16'h0003, "R7");
        acc(1, 3'd5, 8'h00, 3'd1, 0, 0, 0, "R7");
        acc(1, 3'd0, 8'h00, 0, 0, 0, 0, "R7");
        acc(1, 3'd6, 8'h00, 3'd1, 0, 0, 0, "R7");

        // R9 event wins over a clear in the same cycle
        acc(0, 3'd0, 8'h00, 0, 0, 0, 16'h1000, "R9");
        acc(1, 3'd1, 8'h01, 0, 8'h10, 0, 16'h1000, "R9");
        acc(1, 3'd0, 8'h01, 0, 0, 0, 0, "R9");
        acc(1, 3'd3, 8'h21, 0, 8'h10, 0, 0, "R6");
        acc(1, 3'd0, 8'h01, 0, 0, 0, 0, "R6");

        // R10 general-register window
        acc(1, 3'd3, 8'h05, 0, 8'hEE, 0, 0, "R10");
        acc(1, 3'd2, 8'h1F, 0, 0, 0, 0, "R10");
        acc(1, 3'd0, 8'h05, 0, 0, 0, 0, "R10");

        // R12 undefined operation
        acc(1, 3'd7, 8'h05, 0, 8'h00, 0, 0, "R12");
        acc(1, 3'd0, 8'h05, 0, 0, 0, 0, "R12");

        // R11 reset after activity
        do_reset();
        acc(1, 3'd0, 8'h05, 0, 0, 0, 0, "R11");
        acc(1, 3'd2, 8'h60, 0, 0, 0, 0, "R11");
        acc(1, 3'd2, 8'h60, 0, 0, 1, 0, "R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule